// File: doc/BRIEF.md
# Speculative Load Address Table

This block is a small associative table that catches memory-ordering violations when the scheduler has moved a load above stores that came before it in program order. When the hoisted load issues, the table records the load's destination register tag together with its byte address and access size. Every store that follows presents its own address and size. Any recorded load whose byte range overlaps the store's byte range is invalidated.

At the load's original position in the program, a check operation supplies the same register tag. One cycle later the table answers either "ok" or "reload". Ok means the speculatively loaded value is still good. Reload means the load must be executed again. A tag with no live entry always gets a reload, so a lost or evicted record can never let a stale value through. The reload itself and the cache access that goes with it belong to the surrounding pipeline.

Top module: `ld_spec_table`

## Requirements
- R1: After an advanced load on tag T, a check on T with no overlapping store in between returns ok.
- R2: A store whose byte range overlaps a recorded load's range invalidates that entry, and a later check on its tag returns reload. A size code s means 2^s bytes: 0 is 1 byte, 1 is 2, 2 is 4 and 3 is 8.
- R3: A store whose byte range does not overlap has no effect. This includes a store that ends on the byte just before the load's range.
- R4: An advanced load on a tag already held replaces that entry's address and size, so only the newest range is watched.
- R5: A check on a tag that has no valid entry returns reload.
- R6: A check that returns ok leaves its entry in place. After a reload, the next check on that tag also returns reload.
- R7: When a store and a check arrive in the same cycle, the store is applied first.
- R8: When an advanced load and a store arrive in the same cycle, the store does not invalidate the newly recorded load.
- R9: A new tag takes the lowest-numbered free entry. When the table is full, it replaces the entry chosen by a round-robin pointer. The pointer starts at entry 0 and advances by one on each replacement.
- R10: `chk_resp` is high exactly in the cycle after `chk_valid`. In that cycle exactly one of `chk_ok` and `chk_reload` is high. All three are low otherwise.
- R11: Reset empties the table and drives all three outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | An advanced load is recorded this cycle |
| ld_tag | input | TAG_W | Destination register tag of the load |
| ld_addr | input | ADDR_W | Byte address of the load |
| ld_size | input | 2 | Load size code (2^code bytes) |
| st_valid | input | 1 | A store is presented this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| st_size | input | 2 | Store size code (2^code bytes) |
| chk_valid | input | 1 | A check is requested this cycle |
| chk_tag | input | TAG_W | Register tag being checked |
| chk_resp | output | 1 | Registered: a check answer is present |
| chk_ok | output | 1 | Registered: the speculative value is valid |
| chk_reload | output | 1 | Registered: the load must be re-executed |

## Verification
The overlap test is tried against stores that end just before a load, cross its first byte, fall inside it, or lie just past its end. Comparing adjacent and crossing stores separates a correct byte-range comparison from one that compares only base addresses or is off by one. Stores paired with a check or a load in the same cycle show whether the store is ordered before the check and whether it misses the newly written entry. A fill-then-overflow sequence with an invalidation in the middle checks both the free-slot-first rule and the round-robin victim order.

// File: rtl/slat_pkg.sv
package slat_pkg;

  // Access size code: bytes = 1 << code (1, 2, 4 or 8 bytes)
  typedef logic [1:0] size_code_t;

  function automatic logic [3:0] size_bytes(size_code_t code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/slat_overlap.sv
module slat_overlap
  import slat_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] a_addr,
  input  size_code_t        a_size,
  input  logic [ADDR_W-1:0] b_addr,
  input  size_code_t        b_size,
  output logic              hit
);
  // One extra bit so that end = start + length cannot wrap
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] a_lo, a_end, b_lo, b_end;

  always_comb begin
    a_lo  = {1'b0, a_addr};
    b_lo  = {1'b0, b_addr};
    a_end = a_lo + EXT_W'(size_bytes(a_size));
    b_end = b_lo + EXT_W'(size_bytes(b_size));
    hit   = (a_lo < b_end) && (b_lo < a_end);
  end

endmodule

// File: rtl/slat_victim.sv
module slat_victim #(
  parameter  int ENTRIES = 4,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] busy,
  input  logic [ENTRIES-1:0] same_tag,
  input  logic               alloc,
  output logic [IDX_W-1:0]   idx
);
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] tag_idx, free_idx;
  logic             any_free, evict;

  always_comb begin
    tag_idx  = '0;
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (same_tag[i]) tag_idx = IDX_W'(i);
    end
    evict = alloc && !(|same_tag) && !any_free;
    if (|same_tag)    idx = tag_idx;
    else if (any_free) idx = free_idx;
    else              idx = ptr;
  end

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (evict)
      ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
  end

  // R9
  rr_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !evict |=> $stable(ptr));

  generate
    if (ENTRIES > 1) begin : g_adv
      // R9
      rr_ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        evict |=> !$stable(ptr));
    end
  endgenerate

endmodule

// File: rtl/ld_spec_table.sv
module ld_spec_table
  import slat_pkg::*;
#(
  parameter  int ENTRIES = 4,
  parameter  int TAG_W   = 6,
  parameter  int ADDR_W  = 16,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              chk_valid,
  input  logic [TAG_W-1:0]  chk_tag,
  output logic              chk_resp,
  output logic              chk_ok,
  output logic              chk_reload
);
  // Entry storage: data fields carry no reset, only the valid bits do
  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   ent_tag  [ENTRIES];
  logic [ADDR_W-1:0]  ent_addr [ENTRIES];
  size_code_t         ent_size [ENTRIES];

  logic [ENTRIES-1:0] ovl, kill, ld_same, chk_match;
  logic [IDX_W-1:0]   alloc_idx;
  logic               chk_hit;

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      slat_overlap #(.ADDR_W(ADDR_W)) u_ovl (
        .a_addr (ent_addr[i]),
        .a_size (ent_size[i]),
        .b_addr (st_addr),
        .b_size (st_size),
        .hit    (ovl[i])
      );
      assign kill[i]      = st_valid && vld[i] && ovl[i];
      assign ld_same[i]   = vld[i] && (ent_tag[i] == ld_tag);
      // Store is applied before the check: a killed entry does not match
      assign chk_match[i] = vld[i] && !kill[i] && (ent_tag[i] == chk_tag);

      // R2
      store_kill_chk: assert property (@(posedge clk) disable iff (rst)
        (kill[i] && !(ld_valid && alloc_idx == IDX_W'(i))) |=> !vld[i]);
    end
  endgenerate

  assign chk_hit = |chk_match;

  slat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk      (clk),
    .rst      (rst),
    .busy     (vld & ~kill),
    .same_tag (ld_same),
    .alloc    (ld_valid),
    .idx      (alloc_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      vld <= vld & ~kill;
      if (ld_valid) vld[alloc_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_valid) begin
      ent_tag[alloc_idx]  <= ld_tag;
      ent_addr[alloc_idx] <= ld_addr;
      ent_size[alloc_idx] <= ld_size;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_resp   <= 1'b0;
      chk_ok     <= 1'b0;
      chk_reload <= 1'b0;
    end else begin
      chk_resp   <= chk_valid;
      chk_ok     <= chk_valid && chk_hit;
      chk_reload <= chk_valid && !chk_hit;
    end
  end

  // At most one live entry per tag
  logic dup_tag;
  always_comb begin
    dup_tag = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (vld[i] && vld[j] && ent_tag[i] == ent_tag[j]) dup_tag = 1'b1;
  end

  // R4
  no_dup_tag_chk: assert property (@(posedge clk) disable iff (rst) !dup_tag);

  // R10
  resp_follows_chk_chk: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> chk_resp);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !(chk_resp || chk_ok || chk_reload));

  // R10
  one_answer_chk: assert property (@(posedge clk) disable iff (rst)
    chk_resp |-> $countones({chk_ok, chk_reload}) == 1);

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (vld == '0 && !chk_resp && !chk_ok && !chk_reload));

endmodule

// File: tb/ld_spec_table_bench.sv
`timescale 1ns/1ps
module ld_spec_table_bench;
  localparam int TAG_W  = 6;
  localparam int ADDR_W = 16;

  typedef struct packed {
    logic              ldv;
    logic [TAG_W-1:0]  ltag;
    logic [ADDR_W-1:0] laddr;
    logic [1:0]        lsz;
    logic              stv;
    logic [ADDR_W-1:0] saddr;
    logic [1:0]        ssz;
    logic              cv;
    logic [TAG_W-1:0]  ctag;
    logic              eok;
    logic              erl;
    logic [3:0]        req;
  } vec_t;

  function automatic vec_t mk(logic ldv, int ltag, int laddr, int lsz,
                              logic stv, int saddr, int ssz,
                              logic cv, int ctag, logic eok, logic erl, int req);
    vec_t v;
    v.ldv = ldv; v.ltag = TAG_W'(ltag); v.laddr = ADDR_W'(laddr); v.lsz = 2'(lsz);
    v.stv = stv; v.saddr = ADDR_W'(saddr); v.ssz = 2'(ssz);
    v.cv = cv; v.ctag = TAG_W'(ctag); v.eok = eok; v.erl = erl; v.req = 4'(req);
    return v;
  endfunction

  function automatic string req_name(logic [3:0] r);
    case (r)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; default: return "R11";
    endcase
  endfunction

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    mk(1, 1, 'h100, 2, 0, 0,     0, 0, 0, 0, 0, 10), // record tag1 4B @100
    mk(0, 0, 0,     0, 0, 0,     0, 1, 1, 1, 0, 1),  // R1 clean check
    mk(0, 0, 0,     0, 1, 'h104, 2, 1, 1, 1, 0, 3),  // R3 store just past end
    mk(0, 0, 0,     0, 1, 'h103, 0, 1, 1, 0, 1, 7),  // R7 store + check same cycle
    mk(0, 0, 0,     0, 0, 0,     0, 1, 1, 0, 1, 2),  // R2 entry gone
    mk(1, 2, 'h200, 3, 0, 0,     0, 0, 0, 0, 0, 10), // tag2 8B @200
    mk(0, 0, 0,     0, 1, 'h1FE, 1, 1, 2, 1, 0, 3),  // R3 store ends just before
    mk(0, 0, 0,     0, 1, 'h1FF, 1, 1, 2, 0, 1, 2),  // R2 crossing first byte
    mk(0, 0, 0,     0, 0, 0,     0, 1, 7, 0, 1, 5),  // R5 unknown tag
    mk(1, 3, 'h300, 0, 0, 0,     0, 0, 0, 0, 0, 10),
    mk(1, 3, 'h400, 0, 0, 0,     0, 0, 0, 0, 0, 10), // R4 overwrite tag3
    mk(0, 0, 0,     0, 1, 'h300, 0, 1, 3, 1, 0, 4),  // R4 old range unwatched
    mk(0, 0, 0,     0, 1, 'h400, 0, 1, 3, 0, 1, 4),  // R4 new range watched
    mk(1, 4, 'h500, 2, 1, 'h500, 2, 0, 0, 0, 0, 8),  // R8 load + store same cycle
    mk(0, 0, 0,     0, 0, 0,     0, 1, 4, 1, 0, 8),
    mk(0, 0, 0,     0, 0, 0,     0, 1, 4, 1, 0, 6),  // R6 ok keeps entry
    mk(0, 0, 0,     0, 1, 'h502, 0, 0, 0, 0, 0, 10), // store inside range
    mk(0, 0, 0,     0, 0, 0,     0, 1, 4, 0, 1, 2),
    mk(0, 0, 0,     0, 0, 0,     0, 1, 4, 0, 1, 6)   // R6 reload persists
  };

  logic clk = 1'b0;
  logic rst;
  logic ld_valid, st_valid, chk_valid;
  logic [TAG_W-1:0]  ld_tag, chk_tag;
  logic [ADDR_W-1:0] ld_addr, st_addr;
  logic [1:0]        ld_size, st_size;
  logic chk_resp, chk_ok, chk_reload;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ld_spec_table #(.ENTRIES(4), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_ld_spec_table (
    .clk, .rst, .ld_valid, .ld_tag, .ld_addr, .ld_size,
    .st_valid, .st_addr, .st_size, .chk_valid, .chk_tag,
    .chk_resp, .chk_ok, .chk_reload
  );

  task automatic expect3(logic [2:0] exp, string req);
    tests++;
    if ({chk_resp, chk_ok, chk_reload} !== exp) begin
      fails++;
      $display("FAIL %s resp/ok/reload actual=%b expected=%b", req,
               {chk_resp, chk_ok, chk_reload}, exp);
    end
  endtask

  // Drive one cycle at a negedge, check the registered answer at the next one
  task automatic run(vec_t v);
    ld_valid = v.ldv; ld_tag = v.ltag; ld_addr = v.laddr; ld_size = v.lsz;
    st_valid = v.stv; st_addr = v.saddr; st_size = v.ssz;
    chk_valid = v.cv; chk_tag = v.ctag;
    @(negedge clk);
    ld_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0;
    expect3({v.cv, v.eok, v.erl}, req_name(v.req));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    ld_valid = 0; st_valid = 0; chk_valid = 1'b1;
    ld_tag = '0; ld_addr = '0; ld_size = '0;
    st_addr = '0; st_size = '0; chk_tag = '0;
    @(negedge clk);
    @(negedge clk);
    expect3(3'b000, "R11");           // check held during reset: outputs stay low
    chk_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    expect3(3'b000, "R11");

    for (int k = 0; k < NV; k++) run(VEC[k]);

    // R11: reset forgets a recorded load
    run(mk(1, 9, 'h900, 2, 0, 0, 0, 0, 0, 0, 0, 11));
    do_reset();
    run(mk(0, 0, 0, 0, 0, 0, 0, 1, 9, 0, 1, 11));

    // R9: fill, overflow with round-robin, then free-slot preference
    do_reset();
    for (int t = 10; t < 14; t++) run(mk(1, t, 'h1000 + t * 16, 2, 0, 0, 0, 0, 0, 0, 0, 9));
    run(mk(1, 14, 'h1000 + 14 * 16, 2, 0, 0, 0, 0, 0, 0, 0, 9)); // replaces entry 0
    run(mk(0, 0, 0, 0, 0, 0, 0, 1, 10, 0, 1, 9));
    run(mk(0, 0, 0, 0, 0, 0, 0, 1, 11, 1, 0, 9));
    run(mk(1, 15, 'h1000 + 15 * 16, 2, 0, 0, 0, 0, 0, 0, 0, 9)); // replaces entry 1
    run(mk(0, 0, 0, 0, 0, 0, 0, 1, 11, 0, 1, 9));
    run(mk(0, 0, 0, 0, 0, 0, 0, 1, 14, 1, 0, 9));
    run(mk(0, 0, 0, 0, 1, 'h1000 + 13 * 16, 0, 1, 13, 0, 1, 2)); // frees entry 3
    run(mk(1, 16, 'h2000, 2, 0, 0, 0, 0, 0, 0, 0, 9));           // takes entry 3
    run(mk(0, 0, 0, 0, 0, 0, 0, 1, 12, 1, 0, 9));                // pointer victim spared
    run(mk(0, 0, 0, 0, 0, 0, 0, 1, 15, 1, 0, 9));
    run(mk(0, 0, 0, 0, 0, 0, 0, 1, 16, 1, 0, 9));

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule